// File: doc/BRIEF.md
# Queued Invalidation Descriptor Decoder and Dispatcher

This block sits behind the fetch stage of a translation unit's invalidation queue. It accepts one descriptor per cycle, up to 256 bits wide and presented as four 64-bit words. In the narrow 128-bit format the two upper words are zero. The block checks the reserved fields, decodes the descriptor type, and fires exactly one command pulse carrying the decoded fields. The possible commands are: context-cache invalidate, IOTLB invalidate, device-IOTLB invalidate, interrupt-entry-cache invalidate, status write of a wait descriptor, and completion interrupt of a wait descriptor. A descriptor that fails any check produces an error pulse instead of an acknowledge. The cache structures and the memory write that follow are outside this block.

The controller has two states. In `ST_RUN` it decodes every presented descriptor, and on success it advances the queue head index and records the type. The transition `RUN_TO_HALT` is taken when a descriptor fails. In `ST_HALT` the queue-error flag is raised, and every presented descriptor is dropped with no pulse, no head change and no type record. The transition `HALT_TO_RUN` is taken when software asserts the clear input. The state register is the only sequencing element, and the decode is combinational between it and the output registers. Results therefore appear exactly one cycle after the descriptor.

Field layout used throughout (w0..w3 are bits 63:0, 127:64, 191:128 and 255:192 of the descriptor):
- The type is held in w0[3:0], with these codes: 1 context, 2 IOTLB, 3 device-IOTLB, 4 interrupt-entry cache, 5 wait.
- The granularity is held in w0[5:4]. Domain ID is w0[31:16], source ID is w0[47:32] and function mask is w0[49:48].
- The address mask is w1[5:0] and the page address is w1[63:12].

Top module: `idd_dispatch`

## Requirements
- R1: During and after reset, all command pulses, the acknowledge and the error are low. The head index, the last-type record and the queue-error flag are zero.
- R2: A descriptor with any nonzero bit in w2 or w3 is an error, whatever its type, and it leaves the last-type record unchanged.
- R3: When w2 and w3 are zero, w0[3:0] is written into the last-type record, even when the type is unknown. Type codes 0 and 6..15 are errors.
- R4: Context descriptor (type 1): granularity 01 (global) and 10 (domain) both dispatch with device-select low. Granularity 11 dispatches with device-select high, the source ID and the function mask. Domain ID, source ID and mask are always output.
- R5: A context descriptor is an error when granularity is 00, when w1 is nonzero, or when w0[15:6] or w0[63:50] is nonzero.
- R6: IOTLB descriptor (type 2): the block outputs granularity (01 global, 10 domain, 11 page), the domain ID, and the address mask and page address from w1. It is an error when granularity is 00 or when w0[15:6], w0[63:32] or w1[11:6] is nonzero.
- R7: A page-granular IOTLB descriptor whose address mask w1[5:0] exceeds MAX_AM (default 9) is an error. Address mask 9 is accepted.
- R8: Device-IOTLB descriptor (type 3): the source ID splits into bus (w0[47:40]) and device/function (w0[39:32]). Size is w1[0] and the address is w1[63:12]. It is an error when w0[31:4], w0[63:48] or w1[11:1] is nonzero.
- R9: Interrupt-entry-cache descriptor (type 4): the block outputs the global flag w0[4] and the index w0[47:32]. It is an error when w0[31:5], w0[63:48] or w1 is nonzero.
- R10: Wait descriptor (type 5) with status-write flag w0[5] set and interrupt flag w0[4] clear: a status-write request carries data w0[63:32] and address w1. An address with w1[1:0] nonzero is an error.
- R11: A wait descriptor with only the interrupt flag set pulses the completion interrupt. A wait descriptor with neither flag set, with both flags set, or with w0[31:6] nonzero is an error.
- R12: Each result is registered and appears in the cycle after the descriptor is taken. Every pulse lasts one cycle, and at most one of the commands and the error is high in any cycle. Acknowledge accompanies every command and never the error.
- R13: The head index increments (modulo 2^HEAD_W) exactly when a descriptor is acknowledged and holds otherwise.
- R14: An error sets the sticky queue-error flag. While it is set, presented descriptors are dropped. A descriptor presented in the same cycle as the clear is also dropped, and the flag falls on that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_data | input | 256 | Descriptor words w3..w0 |
| err_clear | input | 1 | Software clear of the queue-error flag |
| desc_ack | output | 1 | Descriptor accepted (pulse) |
| desc_err | output | 1 | Descriptor rejected (pulse) |
| q_err | output | 1 | Sticky queue-error flag |
| head_idx | output | HEAD_W | Queue head index |
| last_type | output | 4 | Type code of the last decoded descriptor |
| cc_vld | output | 1 | Context-cache invalidate pulse |
| cc_dev_sel | output | 1 | Device-selective context invalidate |
| cc_did | output | 16 | Context domain ID |
| cc_sid | output | 16 | Context source ID |
| cc_fmask | output | 2 | Context function mask |
| tlb_vld | output | 1 | IOTLB invalidate pulse |
| tlb_gran | output | 2 | IOTLB granularity |
| tlb_did | output | 16 | IOTLB domain ID |
| tlb_addr | output | 52 | IOTLB page address (4 KiB units) |
| tlb_am | output | 6 | IOTLB address mask |
| dev_vld | output | 1 | Device-IOTLB invalidate pulse |
| dev_bus | output | 8 | Device bus number |
| dev_devfn | output | 8 | Device/function number |
| dev_size | output | 1 | Device-IOTLB size flag |
| dev_addr | output | 52 | Device-IOTLB address (4 KiB units) |
| iec_vld | output | 1 | Interrupt-entry-cache invalidate pulse |
| iec_global | output | 1 | Global interrupt-entry invalidate |
| iec_index | output | 16 | Interrupt-entry index |
| stw_vld | output | 1 | Status-write request pulse |
| stw_addr | output | 64 | Status-write address |
| stw_data | output | 32 | Status-write data |
| cmpl_irq | output | 1 | Completion-interrupt pulse |

## Verification
The hardest situation to reach is the halted state meeting a clear and a new descriptor in the same cycle. It only happens after a rejected descriptor, and the clear must line up with the descriptor edge. The stimulus first forces a rejection with an unknown type. It then presents a valid descriptor without clearing, and after that raises the clear and a valid descriptor together, checking that both are dropped before a third descriptor dispatches. A second subtle case is a descriptor that is fully valid in its low words but has one stray bit in w2 or w3. The vector table sets single bits in each upper word and checks that the last-type record keeps the value left by the previous descriptor.

// File: rtl/idd_pkg.sv
package idd_pkg;
    localparam int WORD_W    = 64;
    localparam int NUM_WORDS = 4;
    localparam int DESC_W    = WORD_W * NUM_WORDS;
    localparam int TYPE_W    = 4;
    localparam int ID_W      = 16;
    localparam int FM_W      = 2;
    localparam int AM_W      = 6;
    localparam int PAGE_SH   = 12;
    localparam int PADDR_W   = WORD_W - PAGE_SH;
    localparam int SDATA_W   = 32;

    localparam logic [TYPE_W-1:0] TY_CTX  = 4'd1;
    localparam logic [TYPE_W-1:0] TY_TLB  = 4'd2;
    localparam logic [TYPE_W-1:0] TY_DEV  = 4'd3;
    localparam logic [TYPE_W-1:0] TY_IEC  = 4'd4;
    localparam logic [TYPE_W-1:0] TY_WAIT = 4'd5;

    typedef enum logic [2:0] {
        K_NONE, K_CTX, K_TLB, K_DEV, K_IEC, K_STW, K_IRQ, K_ERR
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                type_seen;
        logic [TYPE_W-1:0]   type_code;
        logic                ctx_dev;
        logic [1:0]          gran;
        logic [ID_W-1:0]     did;
        logic [ID_W-1:0]     sid;
        logic [FM_W-1:0]     fmask;
        logic [AM_W-1:0]     am;
        logic [PADDR_W-1:0]  paddr;
        logic                dsize;
        logic                iec_glob;
        logic [WORD_W-1:0]   st_addr;
        logic [SDATA_W-1:0]  st_data;
    } verdict_t;
endpackage

// File: rtl/idd_check.sv
module idd_check
    import idd_pkg::*;
#(
    parameter int MAX_AM = 9
) (
    input  logic [DESC_W-1:0] desc,
    output verdict_t          vd
);
    localparam logic [AM_W-1:0] AM_LIMIT = AM_W'(MAX_AM);

    logic [WORD_W-1:0] w0, w1;
    logic [NUM_WORDS-1:2] upper_word_nz;
    logic upper_nz;

    assign w0 = desc[0 +: WORD_W];
    assign w1 = desc[WORD_W +: WORD_W];

    for (genvar g = 2; g < NUM_WORDS; g++) begin : g_upper
        assign upper_word_nz[g] = |desc[g*WORD_W +: WORD_W];
    end
    assign upper_nz = |upper_word_nz;

    // Type-specific reserved-field and encoding checks
    logic ctx_ok, tlb_ok, dev_ok, iec_ok, stw_ok, irq_ok;
    logic [1:0] gran;
    logic sw_flag, irq_flag;

    assign gran     = w0[5:4];
    assign sw_flag  = w0[5];
    assign irq_flag = w0[4];

    assign ctx_ok = (gran != 2'b00) && (w0[15:6] == '0) &&
                    (w0[63:50] == '0) && (w1 == '0);
    assign tlb_ok = (gran != 2'b00) && (w0[15:6] == '0) &&
                    (w0[63:32] == '0) && (w1[11:6] == '0) &&
                    !((gran == 2'b11) && (w1[AM_W-1:0] > AM_LIMIT));
    assign dev_ok = (w0[31:4] == '0) && (w0[63:48] == '0) &&
                    (w1[11:1] == '0);
    assign iec_ok = (w0[31:5] == '0) && (w0[63:48] == '0) && (w1 == '0);
    assign stw_ok = (w0[31:6] == '0) && sw_flag && !irq_flag &&
                    (w1[1:0] == 2'b00);
    assign irq_ok = (w0[31:6] == '0) && !sw_flag && irq_flag;

    always_comb begin
        vd           = '0;
        vd.type_seen = !upper_nz;
        vd.type_code = w0[TYPE_W-1:0];
        vd.gran      = gran;
        vd.ctx_dev   = (gran == 2'b11);
        vd.did       = w0[31:16];
        vd.sid       = w0[47:32];
        vd.fmask     = w0[49:48];
        vd.am        = w1[AM_W-1:0];
        vd.paddr     = w1[WORD_W-1:PAGE_SH];
        vd.dsize     = w1[0];
        vd.iec_glob  = w0[4];
        vd.st_addr   = w1;
        vd.st_data   = w0[WORD_W-1:WORD_W-SDATA_W];
        vd.kind      = K_ERR;
        if (!upper_nz) begin
            case (w0[TYPE_W-1:0])
                TY_CTX:  vd.kind = ctx_ok ? K_CTX : K_ERR;
                TY_TLB:  vd.kind = tlb_ok ? K_TLB : K_ERR;
                TY_DEV:  vd.kind = dev_ok ? K_DEV : K_ERR;
                TY_IEC:  vd.kind = iec_ok ? K_IEC : K_ERR;
                TY_WAIT: vd.kind = stw_ok ? K_STW : (irq_ok ? K_IRQ : K_ERR);
                default: vd.kind = K_ERR;
            endcase
        end
    end
endmodule

// File: rtl/idd_head_ctr.sv
module idd_head_ctr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (adv) idx <= idx + 1'b1;
    end
endmodule

// File: rtl/idd_dispatch.sv
module idd_dispatch
    import idd_pkg::*;
#(
    parameter int HEAD_W = 15,
    parameter int MAX_AM = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                desc_valid,
    input  logic [DESC_W-1:0]   desc_data,
    input  logic                err_clear,
    output logic                desc_ack,
    output logic                desc_err,
    output logic                q_err,
    output logic [HEAD_W-1:0]   head_idx,
    output logic [TYPE_W-1:0]   last_type,
    output logic                cc_vld,
    output logic                cc_dev_sel,
    output logic [ID_W-1:0]     cc_did,
    output logic [ID_W-1:0]     cc_sid,
    output logic [FM_W-1:0]     cc_fmask,
    output logic                tlb_vld,
    output logic [1:0]          tlb_gran,
    output logic [ID_W-1:0]     tlb_did,
    output logic [PADDR_W-1:0]  tlb_addr,
    output logic [AM_W-1:0]     tlb_am,
    output logic                dev_vld,
    output logic [7:0]          dev_bus,
    output logic [7:0]          dev_devfn,
    output logic                dev_size,
    output logic [PADDR_W-1:0]  dev_addr,
    output logic                iec_vld,
    output logic                iec_global,
    output logic [ID_W-1:0]     iec_index,
    output logic                stw_vld,
    output logic [WORD_W-1:0]   stw_addr,
    output logic [SDATA_W-1:0]  stw_data,
    output logic                cmpl_irq
);
    typedef enum logic {ST_RUN, ST_HALT} state_e;

    state_e   state_q, state_d;
    verdict_t vd;
    logic     take, fail, adv;

    idd_check #(.MAX_AM(MAX_AM)) u_check (
        .desc (desc_data),
        .vd   (vd)
    );

    assign take = desc_valid && (state_q == ST_RUN);
    assign fail = take && (vd.kind == K_ERR);
    assign adv  = take && (vd.kind != K_ERR);

    idd_head_ctr #(.W(HEAD_W)) u_head (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .idx   (head_idx)
    );

    // Transitions: RUN_TO_HALT on a failed descriptor, HALT_TO_RUN on clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (fail)      state_d = ST_HALT;
            ST_HALT: if (err_clear) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign q_err = (state_q == ST_HALT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ack   <= 1'b0;
            desc_err   <= 1'b0;
            last_type  <= '0;
            cc_vld     <= 1'b0;
            cc_dev_sel <= 1'b0;
            cc_did     <= '0;
            cc_sid     <= '0;
            cc_fmask   <= '0;
            tlb_vld    <= 1'b0;
            tlb_gran   <= '0;
            tlb_did    <= '0;
            tlb_addr   <= '0;
            tlb_am     <= '0;
            dev_vld    <= 1'b0;
            dev_bus    <= '0;
            dev_devfn  <= '0;
            dev_size   <= 1'b0;
            dev_addr   <= '0;
            iec_vld    <= 1'b0;
            iec_global <= 1'b0;
            iec_index  <= '0;
            stw_vld    <= 1'b0;
            stw_addr   <= '0;
            stw_data   <= '0;
            cmpl_irq   <= 1'b0;
        end else begin
            desc_ack <= 1'b0;
            desc_err <= 1'b0;
            cc_vld   <= 1'b0;
            tlb_vld  <= 1'b0;
            dev_vld  <= 1'b0;
            iec_vld  <= 1'b0;
            stw_vld  <= 1'b0;
            cmpl_irq <= 1'b0;
            if (take) begin
                if (vd.type_seen) last_type <= vd.type_code;
                case (vd.kind)
                    K_CTX: begin
                        cc_vld     <= 1'b1;
                        desc_ack   <= 1'b1;
                        cc_dev_sel <= vd.ctx_dev;
                        cc_did     <= vd.did;
                        cc_sid     <= vd.sid;
                        cc_fmask   <= vd.fmask;
                    end
                    K_TLB: begin
                        tlb_vld  <= 1'b1;
                        desc_ack <= 1'b1;
                        tlb_gran <= vd.gran;
                        tlb_did  <= vd.did;
                        tlb_addr <= vd.paddr;
                        tlb_am   <= vd.am;
                    end
                    K_DEV: begin
                        dev_vld   <= 1'b1;
                        desc_ack  <= 1'b1;
                        dev_bus   <= vd.sid[15:8];
                        dev_devfn <= vd.sid[7:0];
                        dev_size  <= vd.dsize;
                        dev_addr  <= vd.paddr;
                    end
                    K_IEC: begin
                        iec_vld    <= 1'b1;
                        desc_ack   <= 1'b1;
                        iec_global <= vd.iec_glob;
                        iec_index  <= vd.sid;
                    end
                    K_STW: begin
                        stw_vld  <= 1'b1;
                        desc_ack <= 1'b1;
                        stw_addr <= vd.st_addr;
                        stw_data <= vd.st_data;
                    end
                    K_IRQ: begin
                        cmpl_irq <= 1'b1;
                        desc_ack <= 1'b1;
                    end
                    default: desc_err <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/idd_dispatch_chk.sv
module idd_dispatch_chk #(
    parameter int HEAD_W = 15,
    parameter int MAX_AM = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              err_clear,
    input logic              desc_ack,
    input logic              desc_err,
    input logic              q_err,
    input logic [HEAD_W-1:0] head_idx,
    input logic              cc_vld,
    input logic              tlb_vld,
    input logic [1:0]        tlb_gran,
    input logic [5:0]        tlb_am,
    input logic              dev_vld,
    input logic              iec_vld,
    input logic              stw_vld,
    input logic [1:0]        stw_lo,
    input logic              cmpl_irq
);
    localparam logic [5:0] AM_LIMIT = 6'(MAX_AM);

    logic [5:0] cmds;
    assign cmds = {cc_vld, tlb_vld, dev_vld, iec_vld, stw_vld, cmpl_irq};

    assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmds, desc_err}));
    assert_ack_has_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ack |-> ($countones(cmds) == 1));
    assert_cmd_has_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmds) == 1) |-> desc_ack);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> (!desc_ack && !desc_err));
    assert_head_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ack |-> ((head_idx - $past(head_idx)) == HEAD_W'(1)));
    assert_head_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_ack |-> $stable(head_idx));
    assert_err_sets_flag_R14: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> q_err);
    assert_flag_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (q_err && !err_clear) |=> q_err);
    assert_halt_blocks_R14: assert property (@(posedge clk) disable iff (!rst_n)
        q_err |=> (!desc_ack && !desc_err));
    assert_am_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_vld && tlb_gran == 2'b11) |-> (tlb_am <= AM_LIMIT));
    assert_stw_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stw_vld |-> (stw_lo == 2'b00));
endmodule

bind idd_dispatch idd_dispatch_chk #(.HEAD_W(HEAD_W), .MAX_AM(MAX_AM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .err_clear  (err_clear),
    .desc_ack   (desc_ack),
    .desc_err   (desc_err),
    .q_err      (q_err),
    .head_idx   (head_idx),
    .cc_vld     (cc_vld),
    .tlb_vld    (tlb_vld),
    .tlb_gran   (tlb_gran),
    .tlb_am     (tlb_am),
    .dev_vld    (dev_vld),
    .iec_vld    (iec_vld),
    .stw_vld    (stw_vld),
    .stw_lo     (stw_addr[1:0]),
    .cmpl_irq   (cmpl_irq)
);

// File: tb/idd_dispatch_bench.sv
module idd_dispatch_bench;
    localparam int HW = 15;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic [255:0]  desc_data = '0;
    logic          err_clear = 1'b0;
    logic          desc_ack, desc_err, q_err;
    logic [HW-1:0] head_idx;
    logic [3:0]    last_type;
    logic          cc_vld, cc_dev_sel;
    logic [15:0]   cc_did, cc_sid;
    logic [1:0]    cc_fmask;
    logic          tlb_vld;
    logic [1:0]    tlb_gran;
    logic [15:0]   tlb_did;
    logic [51:0]   tlb_addr;
    logic [5:0]    tlb_am;
    logic          dev_vld;
    logic [7:0]    dev_bus, dev_devfn;
    logic          dev_size;
    logic [51:0]   dev_addr;
    logic          iec_vld, iec_global;
    logic [15:0]   iec_index;
    logic          stw_vld;
    logic [63:0]   stw_addr;
    logic [31:0]   stw_data;
    logic          cmpl_irq;

    idd_dispatch #(.HEAD_W(HW), .MAX_AM(9)) u_idd_dispatch (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_data(desc_data),
        .err_clear(err_clear), .desc_ack(desc_ack), .desc_err(desc_err),
        .q_err(q_err), .head_idx(head_idx), .last_type(last_type),
        .cc_vld(cc_vld), .cc_dev_sel(cc_dev_sel), .cc_did(cc_did),
        .cc_sid(cc_sid), .cc_fmask(cc_fmask), .tlb_vld(tlb_vld),
        .tlb_gran(tlb_gran), .tlb_did(tlb_did), .tlb_addr(tlb_addr),
        .tlb_am(tlb_am), .dev_vld(dev_vld), .dev_bus(dev_bus),
        .dev_devfn(dev_devfn), .dev_size(dev_size), .dev_addr(dev_addr),
        .iec_vld(iec_vld), .iec_global(iec_global), .iec_index(iec_index),
        .stw_vld(stw_vld), .stw_addr(stw_addr), .stw_data(stw_data),
        .cmpl_irq(cmpl_irq)
    );

    // Expected result kinds; bit position in the pulse vector is 6-kind
    localparam logic [2:0] XK_CC = 3'd0, XK_TLB = 3'd1, XK_DEV = 3'd2,
                           XK_IEC = 3'd3, XK_STW = 3'd4, XK_IRQ = 3'd5,
                           XK_ERR = 3'd6;

    typedef struct packed {
        logic [255:0] d;
        logic [2:0]   k;
        logic [63:0]  f;
        logic [7:0]   rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{{64'h0, 64'h0, 64'h0, 64'h11}, XK_CC, 64'h0, 8'd4},                           // R4 global
        '{{64'h0, 64'h0, 64'h0, 64'h1234_0021}, XK_CC, 64'h48D0_0000, 8'd4},             // R4 domain
        '{{64'h0, 64'h0, 64'h0, 64'h0002_ABCD_0000_0031}, XK_CC, 64'h4_0002_AF36, 8'd4}, // R4 device
        '{{64'h0, 64'h0, 64'h1, 64'h11}, XK_ERR, 64'h0, 8'd5},                           // R5 w1 nonzero
        '{{64'h0, 64'h0, 64'h0, 64'h51}, XK_ERR, 64'h0, 8'd5},                           // R5 reserved w0
        '{{64'h0, 64'h0, 64'h0, 64'h0042_0022}, XK_TLB, 64'h80_1080, 8'd6},              // R6 domain
        '{{64'h0, 64'h0, 64'h0000_0012_3456_7009, 64'h0005_0032}, XK_TLB, 64'hC0_0149, 8'd6}, // R6 page am=9
        '{{64'h0, 64'h0, 64'h0000_0012_3456_700A, 64'h0005_0032}, XK_ERR, 64'h0, 8'd7},  // R7 am=10
        '{{64'h0, 64'h0, 64'h0, 64'h2}, XK_ERR, 64'h0, 8'd6},                            // R6 gran 00
        '{{64'h0, 64'h0, 64'h8000_1001, 64'h0000_3A17_0000_0003}, XK_DEV, 64'h742F_0008_0001, 8'd8}, // R8
        '{{64'h0, 64'h0, 64'h2, 64'h0000_3A17_0000_0003}, XK_ERR, 64'h0, 8'd8},          // R8 reserved w1
        '{{64'h0, 64'h0, 64'h0, 64'h0000_00FF_0000_0014}, XK_IEC, 64'h1_00FF, 8'd9},     // R9
        '{{64'h0, 64'h0, 64'h0, 64'h14}, XK_IEC, 64'h1_0000, 8'd9},                      // R9 global only
        '{{64'h0, 64'h0, 64'h1000_0040, 64'hCAFE_F00D_0000_0025}, XK_STW, 64'hCAFE_F00D_1000_0040, 8'd10}, // R10
        '{{64'h0, 64'h0, 64'h1000_0041, 64'hCAFE_F00D_0000_0025}, XK_ERR, 64'h0, 8'd10}, // R10 misaligned
        '{{64'h0, 64'h0, 64'h0, 64'h15}, XK_IRQ, 64'h0, 8'd11},                          // R11 irq only
        '{{64'h0, 64'h0, 64'h0, 64'h5}, XK_ERR, 64'h0, 8'd11},                           // R11 no flag
        '{{64'h0, 64'h0, 64'h0, 64'h35}, XK_ERR, 64'h0, 8'd11},                          // R11 both flags
        '{{64'h0, 64'h0, 64'h0, 64'h7}, XK_ERR, 64'h0, 8'd3},                            // R3 unknown 7
        '{{64'h0, 64'h0, 64'h0, 64'h0}, XK_ERR, 64'h0, 8'd3},                            // R3 type 0
        '{{64'h1, 64'h0, 64'h0, 64'h11}, XK_ERR, 64'h0, 8'd2},                           // R2 w3 bit
        '{{64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h14}, XK_ERR, 64'h0, 8'd2}          // R2 w2 bit
    };

    int total = 0;
    int bad = 0;
    logic [3:0]    exp_last = 4'h0;
    logic [HW-1:0] exp_head = '0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [6:0] pulses();
        return {cc_vld, tlb_vld, dev_vld, iec_vld, stw_vld, cmpl_irq, desc_err};
    endfunction

    function automatic logic [63:0] observed(input logic [2:0] k);
        case (k)
            XK_CC:  return {29'b0, cc_dev_sel, cc_did, cc_sid, cc_fmask};
            XK_TLB: return {40'b0, tlb_gran, tlb_did, tlb_am};
            XK_DEV: return {15'b0, dev_bus, dev_devfn, dev_size, dev_addr[31:0]};
            XK_IEC: return {47'b0, iec_global, iec_index};
            XK_STW: return {stw_data, stw_addr[31:0]};
            default: return 64'h0;
        endcase
    endfunction

    // Drive for one edge; outputs are then sampled at the following negedge
    task automatic present(input logic [255:0] d);
        @(negedge clk);
        desc_valid = 1'b1;
        desc_data  = d;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_data  = '0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.rq);
        present(v.d);
        chk(rq, "pulses", {57'b0, pulses()}, {57'b0, 7'b1 << (6 - v.k)});
        chk(rq, "ack", {63'b0, desc_ack}, {63'b0, v.k != XK_ERR});
        chk(rq, "fields", observed(v.k), v.f);
        if (v.d[255:128] == '0) exp_last = v.d[3:0];
        chk(rq, "last_type", {60'b0, last_type}, {60'b0, exp_last});
        if (v.k != XK_ERR) exp_head = exp_head + 1'b1;
        chk(rq, "head", {49'b0, head_idx}, {49'b0, exp_head});
        if (v.k == XK_ERR) begin
            chk("R14", "flag set", {63'b0, q_err}, 64'd1);
            clear_err();
            chk("R14", "flag cleared", {63'b0, q_err}, 64'd0);
        end else begin
            @(negedge clk);
            chk("R12", "pulse width", {57'b0, pulses()}, 64'd0);
        end
    endtask

    initial begin
        // R1: reset state while held and after release
        repeat (3) @(negedge clk);
        chk("R1", "pulses in reset", {56'b0, pulses(), desc_ack}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pulses", {56'b0, pulses(), desc_ack}, 64'd0);
        chk("R1", "head", {49'b0, head_idx}, 64'd0);
        chk("R1", "q_err", {63'b0, q_err}, 64'd0);
        chk("R1", "last_type", {60'b0, last_type}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: page address and mask taken from w1
        present({64'h0, 64'h0, 64'h0000_0012_3456_7009, 64'h0005_0032});
        exp_head = exp_head + 1'b1;
        chk("R6", "tlb_addr", {12'b0, tlb_addr}, 64'h0000_0012_3456_7);
        // R8: device address
        present({64'h0, 64'h0, 64'h8000_1001, 64'h0000_3A17_0000_0003});
        exp_head = exp_head + 1'b1;
        chk("R8", "dev_addr", {12'b0, dev_addr}, 64'h8_0001);
        // R10: full 64-bit status address
        present({64'h0, 64'h0, 64'hFFFF_0000_0000_0010, 64'h1234_5678_0000_0025});
        exp_head = exp_head + 1'b1;
        chk("R10", "stw_addr", stw_addr, 64'hFFFF_0000_0000_0010);
        chk("R10", "stw_data", {32'b0, stw_data}, 64'h1234_5678);

        // R12 R13: back-to-back descriptors, one per cycle
        @(negedge clk);
        desc_valid = 1'b1;
        desc_data  = {64'h0, 64'h0, 64'h0, 64'h0000_0007_0000_0004};
        @(negedge clk);
        desc_data  = {64'h0, 64'h0, 64'h0, 64'h15};
        chk("R12", "first of pair", {57'b0, pulses()}, 64'h8);
        chk("R9", "iec index", {48'b0, iec_index}, 64'h7);
        @(negedge clk);
        desc_valid = 1'b0;
        desc_data  = '0;
        chk("R12", "second of pair", {57'b0, pulses()}, 64'h2);
        exp_head = exp_head + 2'd2;
        chk("R13", "head after pair", {49'b0, head_idx}, {49'b0, exp_head});

        // R14: halt, drop while halted, drop on the clear cycle, resume
        present({64'h0, 64'h0, 64'h0, 64'h9});
        chk("R14", "error pulse", {63'b0, desc_err}, 64'd1);
        present({64'h0, 64'h0, 64'h0, 64'h11});
        chk("R14", "dropped while halted", {56'b0, pulses(), desc_ack}, 64'd0);
        chk("R14", "head held", {49'b0, head_idx}, {49'b0, exp_head});
        chk("R14", "type not recorded", {60'b0, last_type}, 64'h9);
        chk("R14", "still halted", {63'b0, q_err}, 64'd1);
        @(negedge clk);
        err_clear  = 1'b1;
        desc_valid = 1'b1;
        desc_data  = {64'h0, 64'h0, 64'h0, 64'h11};
        @(negedge clk);
        err_clear  = 1'b0;
        desc_valid = 1'b0;
        desc_data  = '0;
        chk("R14", "dropped on clear", {56'b0, pulses(), desc_ack}, 64'd0);
        chk("R14", "flag fell", {63'b0, q_err}, 64'd0);
        present({64'h0, 64'h0, 64'h0, 64'h11});
        exp_head = exp_head + 1'b1;
        chk("R14", "resumed", {56'b0, pulses(), desc_ack}, 64'h81);
        chk("R13", "head after resume", {49'b0, head_idx}, {49'b0, exp_head});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule